// File: doc/BRIEF.md
# Pipelined Montgomery Modular Multiplier with Scaled Quotients

This block multiplies two residues modulo an odd modulus n and returns x·y·R⁻¹ reduced into the range [0, 2n), where R = 2·2^(17·NDIG). The radix is 2^17 and the operand width is NDIG digits. The datapath is fully unrolled: each digit of x has its own pipeline stage, so a new operand pair can enter on every clock and a result leaves on every clock. Operands and results stay in the "below 2n" form, so results can be fed straight back as operands with no compare against n.

The first NDIG−1 stages form their quotient digit directly from the low digit of the running sum. This works because they reduce against a pre-scaled modulus whose negated inverse is one, so no multiply by the inverse constant is needed. The caller supplies that scaled modulus as nfs = ⌊n·n0'/2^17⌋ + 1, together with n and n0' = −n⁻¹ mod 2^17. Only the final digit stage reduces against the true modulus. Its quotient comes from a 17-bit truncated multiplier spread over four register stages. A closing stage adds n when the sum is odd and then halves it.

The modulus travels with each operand pair, so neighbouring items may use different moduli. A tag and a valid bit move through the pipeline alongside the data. Any reset is synchronised to the clock before the block uses it.

Top module: `mont_tail_mul`

## Requirements
- R1: If n is odd with 3 ≤ n < 2^(17·NDIG−2), and 0 ≤ x, y < 2n, then out_res < 2n.
- R2: (out_res · 2^(17·NDIG+1)) mod n equals (x · y) mod n.
- R3: A pair offered on consecutive clocks produces results on consecutive clocks, with no stall or bubble.
- R4: out_valid rises exactly NDIG+5 clock edges after the edge that captures in_valid high, counting that capture edge as the first.
- R5: Each result carries the in_tag of its own operand pair, and results leave in issue order.
- R6: A clock with in_valid low produces no result. The number of results equals the number of accepted pairs.
- R7: The modulus, n0' and nfs are taken per item, so back-to-back items with different moduli each satisfy R1 and R2.
- R8: While rst_n is low, and for the first two clocks after it rises, out_valid is 0.
- R9: If x = 0 or y = 0, out_res is exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | The operand pair on the inputs is accepted this clock |
| in_tag | input | TAG_W | Opaque label returned with the result |
| in_x | input | 17·NDIG | Multiplicand, below 2n |
| in_y | input | 17·NDIG | Multiplier, below 2n |
| in_n | input | 17·NDIG | Odd modulus |
| in_nfs | input | 17·NDIG | Scaled modulus ⌊n·n0'/2^17⌋+1 |
| in_n0p | input | 17 | −n⁻¹ mod 2^17 |
| out_valid | output | 1 | A result is present |
| out_tag | output | TAG_W | Tag of the result |
| out_res | output | 17·NDIG | x·y·R⁻¹ mod n, in the range [0, 2n) |

## Verification
Most internal faults show up at the ports as a broken congruence or a result of 2n or more on the very item they hit, NDIG+5 clocks after that item enters. Examples are a misaligned digit in the x delay line, a wrong quotient digit, a skewed modulus delay line or a missing odd fix. A quotient multiplier slice that is out of step with its side channel corrupts every later item and is caught on the first one. The bench therefore checks every result against the congruence and the 2n bound, and it changes the modulus from item to item so that a delay mismatch between the modulus line and the operand line cannot hide.

// File: rtl/mtm_pkg.sv
package mtm_pkg;
  // radix of the datapath, fixed by the multiplier slice width
  localparam int unsigned DIG_W     = 17;
  // register stages inside the truncated quotient multiplier
  localparam int unsigned QM_STAGES = 4;
  // split of the n0' digit for the two partial products
  localparam int unsigned LO_W      = (DIG_W + 1) / 2;
  localparam int unsigned HI_W      = DIG_W - LO_W;
endpackage

// File: rtl/mtm_iter_stage.sv
module mtm_iter_stage
  import mtm_pkg::*;
#(
  parameter int unsigned NDIG  = 8,
  parameter int unsigned TAG_W = 8,
  parameter bit          FIRST = 1'b0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           v_i,
  input  logic [TAG_W-1:0]               tag_i,
  input  logic [DIG_W*(NDIG+1)+1:0]      a_i,
  input  logic [DIG_W*NDIG-1:0]          x_i,
  input  logic [DIG_W*NDIG-1:0]          y_i,
  input  logic [DIG_W*NDIG-1:0]          nfs_i,
  output logic                           v_o,
  output logic [TAG_W-1:0]               tag_o,
  output logic [DIG_W*(NDIG+1)+1:0]      a_o,
  output logic [DIG_W*NDIG-1:0]          x_o,
  output logic [DIG_W*NDIG-1:0]          y_o,
  output logic [DIG_W*NDIG-1:0]          nfs_o
);
  localparam int unsigned XW = DIG_W * NDIG;
  localparam int unsigned AW = DIG_W * (NDIG + 1) + 2;

  logic [AW-1:0]    base;
  logic [AW-1:0]    prod;
  logic [AW-1:0]    acc;
  logic [DIG_W-1:0] qdig;
  logic [AW-1:0]    a_nx;
  logic [XW-1:0]    x_nx;

  // the first iteration starts from an empty accumulator
  generate
    if (FIRST) begin : g_first
      assign base = '0;
    end else begin : g_rest
      assign base = a_i;
    end
  endgenerate

  always_comb begin
    prod = AW'(x_i[DIG_W-1:0]) * AW'(y_i);
    acc  = base + prod;
    // scaled modulus has inverse -1, so quotient is the low digit itself
    qdig = acc[DIG_W-1:0];
    a_nx = (acc >> DIG_W) + AW'(qdig) * AW'(nfs_i);
    // consumed digit drops off the x line
    x_nx = x_i >> DIG_W;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      tag_o <= tag_i;
      a_o   <= a_nx;
      x_o   <= x_nx;
      y_o   <= y_i;
      nfs_o <= nfs_i;
    end
  end
endmodule

// File: rtl/mtm_quot_mul.sv
module mtm_quot_mul
  import mtm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_i,
  input  logic [DIG_W-1:0] t_i,
  input  logic [DIG_W-1:0] k_i,
  output logic             v_o,
  output logic [DIG_W-1:0] u_o
);
  logic [QM_STAGES-1:0] vs;
  logic [DIG_W-1:0]     t1, k1, lo2, t2, lo3, hi3, u4;
  logic [HI_W-1:0]      khi2;
  logic [DIG_W-1:0]     lo_nx, hi_nx, u_nx;

  // product truncated to one digit: low half then shifted high half
  always_comb begin
    lo_nx = t1 * DIG_W'(k1[LO_W-1:0]);
    hi_nx = (t2 * DIG_W'(khi2)) << LO_W;
    u_nx  = lo3 + hi3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs <= '0;
    else        vs <= {vs[QM_STAGES-2:0], v_i};
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      t1 <= t_i;
      k1 <= k_i;
    end
    if (vs[0]) begin
      lo2  <= lo_nx;
      t2   <= t1;
      khi2 <= k1[DIG_W-1:LO_W];
    end
    if (vs[1]) begin
      lo3 <= lo2;
      hi3 <= hi_nx;
    end
    if (vs[2]) u4 <= u_nx;
  end

  assign v_o = vs[QM_STAGES-1];
  assign u_o = u4;
endmodule

// File: rtl/mtm_last_stage.sv
module mtm_last_stage
  import mtm_pkg::*;
#(
  parameter int unsigned NDIG  = 8,
  parameter int unsigned TAG_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      v_i,
  input  logic [TAG_W-1:0]          tag_i,
  input  logic [DIG_W*(NDIG+1)+1:0] a_i,
  input  logic [DIG_W-1:0]          xd_i,
  input  logic [DIG_W*NDIG-1:0]     y_i,
  input  logic [DIG_W*NDIG-1:0]     n_i,
  input  logic [DIG_W-1:0]          k_i,
  output logic                      v_o,
  output logic [TAG_W-1:0]          tag_o,
  output logic [DIG_W*(NDIG+1)+1:0] a_o,
  output logic [DIG_W*NDIG-1:0]     n_o
);
  localparam int unsigned XW = DIG_W * NDIG;
  localparam int unsigned AW = DIG_W * (NDIG + 1) + 2;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [AW-1:0]    a;
    logic [DIG_W-1:0] xd;
    logic [XW-1:0]    y;
    logic [XW-1:0]    n;
  } side_t;

  logic [DIG_W-1:0]     t_in;
  logic                 qv;
  logic [DIG_W-1:0]     qu;
  side_t                sd [QM_STAGES];
  logic [QM_STAGES-1:0] sv;
  side_t                last;
  logic [AW-1:0]        sum;
  logic [AW-1:0]        a_nx;

  always_comb begin
    t_in = a_i[DIG_W-1:0] + xd_i * y_i[DIG_W-1:0];
  end

  mtm_quot_mul u_qm (
    .clk   (clk),
    .rst_n (rst_n),
    .v_i   (v_i),
    .t_i   (t_in),
    .k_i   (k_i),
    .v_o   (qv),
    .u_o   (qu)
  );

  // side channel waits while the quotient digit is formed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sv <= '0;
    else        sv <= {sv[QM_STAGES-2:0], v_i};
  end

  always_ff @(posedge clk) begin
    if (v_i) sd[0] <= '{tag: tag_i, a: a_i, xd: xd_i, y: y_i, n: n_i};
  end

  generate
    for (genvar j = 1; j < QM_STAGES; j++) begin : g_side
      always_ff @(posedge clk) begin
        if (sv[j-1]) sd[j] <= sd[j-1];
      end
    end
  endgenerate

  assign last = sd[QM_STAGES-1];

  always_comb begin
    sum  = last.a + AW'(last.xd) * AW'(last.y) + AW'(qu) * AW'(last.n);
    a_nx = sum >> DIG_W;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= sv[QM_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (sv[QM_STAGES-1]) begin
      tag_o <= last.tag;
      a_o   <= a_nx;
      n_o   <= last.n;
    end
  end

  // R1: accumulator out of the scaled stages stays below (b+4)n
  p_acc_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v_i |-> (a_i < AW'(n_i) * AW'((1 << DIG_W) + 4)));

  // R2: true-modulus quotient clears the low digit of the sum
  p_quot_cancel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sv[QM_STAGES-1] |-> (DIG_W'(last.a[DIG_W-1:0] + last.xd * last.y[DIG_W-1:0]
                          + qu * last.n[DIG_W-1:0]) == '0));

  // R4: quotient slice and side channel stay in step
  p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    qv == sv[QM_STAGES-1]);

  // R1: after the last iteration the value is below 3n
  p_last_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> (a_o < AW'(n_o) * AW'(3)));
endmodule

// File: rtl/mtm_halve.sv
module mtm_halve
  import mtm_pkg::*;
#(
  parameter int unsigned NDIG  = 8,
  parameter int unsigned TAG_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      v_i,
  input  logic [TAG_W-1:0]          tag_i,
  input  logic [DIG_W*(NDIG+1)+1:0] a_i,
  input  logic [DIG_W*NDIG-1:0]     n_i,
  output logic                      v_o,
  output logic [TAG_W-1:0]          tag_o,
  output logic [DIG_W*NDIG-1:0]     r_o
);
  localparam int unsigned XW = DIG_W * NDIG;
  localparam int unsigned AW = DIG_W * (NDIG + 1) + 2;

  logic [AW-1:0] fixed;
  logic [XW-1:0] r_nx;
  logic [XW-1:0] n_q;

  // an odd value becomes even by adding the odd modulus, then halves exactly
  always_comb begin
    fixed = a_i + (a_i[0] ? AW'(n_i) : '0);
    r_nx  = XW'(fixed >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      tag_o <= tag_i;
      r_o   <= r_nx;
      n_q   <= n_i;
    end
  end

  // R1: the returned residue is below twice the modulus
  p_out_below_2n_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> ({1'b0, r_o} < {n_q, 1'b0}));
endmodule

// File: rtl/mont_tail_mul.sv
module mont_tail_mul
  import mtm_pkg::*;
#(
  parameter int unsigned NDIG  = 8,
  parameter int unsigned TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [TAG_W-1:0]       in_tag,
  input  logic [DIG_W*NDIG-1:0]  in_x,
  input  logic [DIG_W*NDIG-1:0]  in_y,
  input  logic [DIG_W*NDIG-1:0]  in_n,
  input  logic [DIG_W*NDIG-1:0]  in_nfs,
  input  logic [DIG_W-1:0]       in_n0p,
  output logic                   out_valid,
  output logic [TAG_W-1:0]       out_tag,
  output logic [DIG_W*NDIG-1:0]  out_res
);
  localparam int unsigned XW      = DIG_W * NDIG;
  localparam int unsigned AW      = DIG_W * (NDIG + 1) + 2;
  localparam int unsigned NSCALED = NDIG - 1;

  logic rs1, rs2, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 1'b0;
      rs2 <= 1'b0;
    end else begin
      rs1 <= 1'b1;
      rs2 <= rs1;
    end
  end
  assign rst_s = rs2;

  logic             vld [NSCALED+1];
  logic [TAG_W-1:0] tg  [NSCALED+1];
  logic [AW-1:0]    ac  [NSCALED+1];
  logic [XW-1:0]    xs  [NSCALED+1];
  logic [XW-1:0]    ys  [NSCALED+1];
  logic [XW-1:0]    nf  [NSCALED+1];
  logic [XW-1:0]    nd  [NSCALED+1];
  logic [DIG_W-1:0] kd  [NSCALED+1];

  assign vld[0] = in_valid;
  assign tg[0]  = in_tag;
  assign ac[0]  = '0;
  assign xs[0]  = in_x;
  assign ys[0]  = in_y;
  assign nf[0]  = in_nfs;
  assign nd[0]  = in_n;
  assign kd[0]  = in_n0p;

  generate
    for (genvar k = 0; k < NSCALED; k++) begin : g_iter
      mtm_iter_stage #(
        .NDIG  (NDIG),
        .TAG_W (TAG_W),
        .FIRST (k == 0)
      ) u_stage (
        .clk   (clk),
        .rst_n (rst_s),
        .v_i   (vld[k]),
        .tag_i (tg[k]),
        .a_i   (ac[k]),
        .x_i   (xs[k]),
        .y_i   (ys[k]),
        .nfs_i (nf[k]),
        .v_o   (vld[k+1]),
        .tag_o (tg[k+1]),
        .a_o   (ac[k+1]),
        .x_o   (xs[k+1]),
        .y_o   (ys[k+1]),
        .nfs_o (nf[k+1])
      );

      // true modulus and its inverse digit wait until the last iteration
      always_ff @(posedge clk) begin
        if (vld[k]) begin
          nd[k+1] <= nd[k];
          kd[k+1] <= kd[k];
        end
      end
    end
  endgenerate

  logic             lv;
  logic [TAG_W-1:0] ltag;
  logic [AW-1:0]    la;
  logic [XW-1:0]    ln;

  mtm_last_stage #(
    .NDIG  (NDIG),
    .TAG_W (TAG_W)
  ) u_last (
    .clk   (clk),
    .rst_n (rst_s),
    .v_i   (vld[NSCALED]),
    .tag_i (tg[NSCALED]),
    .a_i   (ac[NSCALED]),
    .xd_i  (xs[NSCALED][DIG_W-1:0]),
    .y_i   (ys[NSCALED]),
    .n_i   (nd[NSCALED]),
    .k_i   (kd[NSCALED]),
    .v_o   (lv),
    .tag_o (ltag),
    .a_o   (la),
    .n_o   (ln)
  );

  mtm_halve #(
    .NDIG  (NDIG),
    .TAG_W (TAG_W)
  ) u_halve (
    .clk   (clk),
    .rst_n (rst_s),
    .v_i   (lv),
    .tag_i (ltag),
    .a_i   (la),
    .n_i   (ln),
    .v_o   (out_valid),
    .tag_o (out_tag),
    .r_o   (out_res)
  );
endmodule

// File: tb/sim_mont_tail_mul.sv
module sim_mont_tail_mul;
  localparam int unsigned NDIG  = 4;
  localparam int unsigned TAG_W = 8;
  localparam int unsigned DW    = 17;
  localparam int unsigned XW    = DW * NDIG;
  localparam int unsigned RB    = DW * NDIG + 1;
  localparam int          LAT   = NDIG + 5;

  typedef logic [255:0] big_t;
  typedef struct {
    big_t             x;
    big_t             y;
    big_t             n;
    logic [TAG_W-1:0] tag;
    int               issue;
    string            req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [TAG_W-1:0] in_tag = '0;
  logic [XW-1:0]    in_x = '0, in_y = '0, in_n = '0, in_nfs = '0;
  logic [DW-1:0]    in_n0p = '0;
  logic             out_valid;
  logic [TAG_W-1:0] out_tag;
  logic [XW-1:0]    out_res;

  int   ncmp = 0, nerr = 0, cyc = 0, sent = 0, got = 0;
  int   prev_issue = -10, prev_out = -10;
  bit   mon_on = 1'b0, timeout = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mont_tail_mul #(.NDIG(NDIG), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_x(in_x), .in_y(in_y), .in_n(in_n), .in_nfs(in_nfs), .in_n0p(in_n0p),
    .out_valid(out_valid), .out_tag(out_tag), .out_res(out_res)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input big_t act, input big_t exp);
    ncmp++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] neg_inv(input logic [DW-1:0] nl);
    logic [DW-1:0] v = nl;
    for (int i = 0; i < 5; i++) v = v * (17'd2 - nl * v);
    return 17'd0 - v;
  endfunction

  function automatic big_t rnd_big();
    return {160'd0, $urandom, $urandom, $urandom};
  endfunction

  function automatic big_t rnd_mod();
    big_t m = rnd_big() & ((big_t'(1) << (XW - 2)) - 1);
    m[0] = 1'b1;
    if (m < 3) m = 3;
    return m;
  endfunction

  task automatic send(input big_t x, input big_t y, input big_t n, input string req);
    exp_t e;
    logic [DW-1:0] k;
    big_t ns;
    @(negedge clk);
    k  = neg_inv(n[DW-1:0]);
    ns = n * big_t'(k);
    in_valid = 1'b1;
    in_tag   = TAG_W'(sent);
    in_x     = x[XW-1:0];
    in_y     = y[XW-1:0];
    in_n     = n[XW-1:0];
    in_n0p   = k;
    in_nfs   = XW'((ns >> DW) + 1);
    e.x = x; e.y = y; e.n = n; e.tag = TAG_W'(sent); e.issue = cyc; e.req = req;
    q.push_back(e);
    sent++;
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (mon_on && out_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R6", "result with nothing issued", 1, 0);
      end else begin
        exp_t e;
        big_t lhs, rhs;
        e = q.pop_front();
        got++;
        chk(out_tag == e.tag, "R5", "tag/order", big_t'(out_tag), big_t'(e.tag));
        chk(cyc - e.issue == LAT, "R4", "latency", big_t'(cyc - e.issue), big_t'(LAT));
        if (e.issue == prev_issue + 1)
          chk(cyc == prev_out + 1, "R3", "back-to-back spacing",
              big_t'(cyc - prev_out), 1);
        prev_issue = e.issue;
        prev_out   = cyc;
        chk(big_t'(out_res) < 2 * e.n, "R1", "result below 2n", big_t'(out_res), 2 * e.n);
        lhs = (big_t'(out_res) << RB) % e.n;
        rhs = (e.x * e.y) % e.n;
        chk(lhs == rhs, e.req, "congruence", lhs, rhs);
        if (e.x == 0 || e.y == 0)
          chk(out_res == '0, "R9", "zero operand", big_t'(out_res), 0);
      end
    end
  end

  task automatic run();
    big_t n, m;
    // R8: quiet in reset and through the synchroniser
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8", "valid in reset", big_t'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "valid after release", big_t'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "valid after release", big_t'(out_valid), 0);
    mon_on = 1'b1;
    // R2/R3: burst under one modulus
    n = rnd_mod();
    for (int i = 0; i < 40; i++) send(rnd_big() % (2 * n), rnd_big() % (2 * n), n, "R2");
    // R7: new modulus every item
    for (int i = 0; i < 30; i++) begin
      m = rnd_mod();
      send(rnd_big() % (2 * m), rnd_big() % (2 * m), m, "R7");
    end
    // R6: gaps between items
    for (int i = 0; i < 20; i++) begin
      m = rnd_mod();
      send(rnd_big() % (2 * m), rnd_big() % (2 * m), m, "R6");
      idle(int'($urandom % 3));
    end
    // R9 and R1 corners
    send(0, 5, 3, "R9");
    send(4, 0, 3, "R9");
    send(5, 5, 3, "R1");
    m = (big_t'(1) << (XW - 2)) - 1;
    send(2 * m - 1, 2 * m - 1, m, "R1");
    send(2 * m - 1, 1, m, "R1");
    send(0, 2 * m - 1, m, "R9");
    idle(LAT + 6);
    chk(got == sent, "R6", "result count", big_t'(got), big_t'(sent));
    chk(q.size() == 0, "R6", "pending after drain", big_t'(q.size()), 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) chk(1'b0, "R4", "watchdog expired", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end
endmodule